// File: doc/BRIEF.md
# Synchronizable Decade Pulse-Per-Second Divider

The block turns a 10 MHz reference clock into a once-per-second strobe by passing it through a chain of cascaded divide-by-ten counters. Every digit of the chain raises a one-clock strobe when it rolls over, so the same chain also yields 1 MHz, 100 kHz, 10 kHz, 1 kHz, 100 Hz and 10 Hz rates next to the 1 Hz one. Two stretched outputs are built from these strobes. The first is a fixed once-per-second pulse. The second follows a rate picked at run time, for example 10 Hz when measurements are taken ten times a second. Both stretched outputs are wide enough for a downstream time-interval input to capture cleanly.

A one-shot alignment lets the whole chain be re-phased to an outside pulse-per-second reference. Software or a board strap pulses an arm input. The next rising edge seen on the reference, after a two-flop synchronizer, clears every digit at once. The chain then runs freely again until it is armed once more. Two copies of the block are meant to sit side by side, one per oscillator being compared, so that the phase of each source is tracked without a break.

Alignment is handled by a three-state machine:
- `SY_IDLE`: the chain runs freely and the reference is ignored.
- `SY_ARMED`: the machine waits for a reference rising edge.
- `SY_ALIGN`: a one-cycle state that clears all digits.

Three transitions connect them:
- T_ARM takes `SY_IDLE` to `SY_ARMED` when `arm_i` is high.
- T_CATCH takes `SY_ARMED` to `SY_ALIGN` on a resynchronized rising edge of the reference.
- T_DONE takes `SY_ALIGN` back to `SY_IDLE` unconditionally.

Top module: `decade_pps_divider`

## Requirements
- R1: While `rst_ni` is low, `tick_o`, `pps_o`, `rate_o` and `armed_o` are all 0, and every digit is held at zero.
- R2: Bit i of `tick_o` is high for exactly one clock every 10^(i+1) clocks. After reset is released, or after an alignment clears the chain, it first rises on the 10^(i+1)-th rising edge. Bit NSTAGES-1 is the once-per-second strobe at defaults (7 stages, 10^7 clocks).
- R3: Whenever bit i of `tick_o` is high, every lower bit of `tick_o` is high in the same cycle.
- R4: A high `arm_i` sampled in `SY_IDLE` makes `armed_o` read 1 from the next clock on.
- R5: While armed, a rising edge of `ref_pps_i` clears the chain on the 4th rising clock edge after the reference rose: two synchronizer flops, the edge detect register, then the `SY_ALIGN` cycle. `armed_o` reads 0 from that same edge on, and the next once-per-second strobe comes exactly 10^NSTAGES clocks after it.
- R6: Reference edges while `armed_o` is 0 do not change the phase of any strobe.
- R7: Only a rising edge aligns. A reference already high when the block is armed causes no alignment until it falls and rises again.
- R8: `pps_o` rises in the same cycle as the last bit of `tick_o` and stays high for exactly PULSE_W clocks (default 100, i.e. 10 us).
- R9: `rate_o` is the tick of stage `rate_sel_i`, stretched to PULSE_W clocks. Value s selects a period of 10^(s+1) clocks, so at defaults 5 selects 10 Hz and 6 selects 1 Hz. Any value of NSTAGES or above selects the last stage.
- R10: A new strobe arriving while a stretched pulse is still high restarts its width. A selected period of PULSE_W clocks or less therefore keeps `rate_o` continuously high from its first strobe on.
- R11: After one alignment the machine is disarmed. Later reference edges do not re-phase the chain until `arm_i` is pulsed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 10 MHz input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_pps_i | input | 1 | External reference pulse, asynchronous |
| arm_i | input | 1 | Arms a single alignment to the reference |
| rate_sel_i | input | SEL_W ($clog2(NSTAGES+1)) | Stage whose strobe drives `rate_o` |
| tick_o | output | NSTAGES | One-clock rollover strobes, bit i at period 10^(i+1) clocks |
| pps_o | output | 1 | Stretched strobe of the last stage |
| rate_o | output | 1 | Stretched strobe of the selected stage |
| armed_o | output | 1 | High from arming until the alignment clears the chain |

## Verification
The bench chases the exact edge on which an alignment lands. It counts clocks from the moment the reference rises, so a synchronizer that is one flop short or long shifts every later strobe, and each of those strobes is reported. It holds the reference high before arming, which catches a level-sensitive alignment because the chain would be cleared early. It sends edges while disarmed and after an alignment, which exposes an arm flag that never clears or a chain that listens while idle, since the once-per-second phase would jump. It also drives an out-of-range rate select and a rate faster than the pulse width. A wrong clamp would show the wrong period, and a stretcher that does not restart would show gaps in a pulse that should stay high.

// File: rtl/ppsdiv_pkg.sv
package ppsdiv_pkg;

    typedef enum logic [1:0] {
        SY_IDLE  = 2'd0,
        SY_ARMED = 2'd1,
        SY_ALIGN = 2'd2
    } sync_state_t;

endpackage

// File: rtl/ppsdiv_ref_sync.sv
module ppsdiv_ref_sync #(
    parameter int SYNC_FF = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic rise_o
);
    logic [SYNC_FF:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SYNC_FF-1:0], ref_i};
        end
    end

    // last synchronizer flop high while the history flop is still low
    assign rise_o = sh_q[SYNC_FF-1] & ~sh_q[SYNC_FF];

    AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o); // R7
endmodule

// File: rtl/ppsdiv_sync_fsm.sv
module ppsdiv_sync_fsm
    import ppsdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic rise_i,
    output logic load_o,
    output logic armed_o
);
    sync_state_t state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SY_IDLE:  if (arm_i)  state_d = SY_ARMED;  // T_ARM
            SY_ARMED: if (rise_i) state_d = SY_ALIGN;  // T_CATCH
            SY_ALIGN: state_d = SY_IDLE;               // T_DONE
            default:  state_d = SY_IDLE;
        endcase
    end

    always_comb begin
        load_o  = (state_q == SY_ALIGN);
        armed_o = (state_q != SY_IDLE);
    end

    AST_ALIGN_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SY_ALIGN) |=> (state_q == SY_IDLE)); // R11
    AST_IDLE_DEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SY_IDLE && !arm_i) |=> (state_q == SY_IDLE)); // R6
    AST_ARM_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SY_IDLE && arm_i) |=> armed_o); // R4
endmodule

// File: rtl/ppsdiv_decade_stage.sv
module ppsdiv_decade_stage #(
    parameter int RADIX = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic en_i,
    output logic wrap_o
);
    localparam int CW = (RADIX > 2) ? $clog2(RADIX) : 1;
    localparam logic [CW-1:0] MAXV = CW'(RADIX - 1);

    logic [CW-1:0] digit_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            digit_q <= '0;
        end else if (load_i) begin
            digit_q <= '0;
        end else if (en_i) begin
            digit_q <= (digit_q == MAXV) ? '0 : digit_q + 1'b1;
        end
    end

    assign wrap_o = en_i & (digit_q == MAXV);

    AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (digit_q == '0)); // R5
    AST_DIGIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        digit_q <= MAXV); // R2
endmodule

// File: rtl/ppsdiv_stretch.sv
module ppsdiv_stretch #(
    parameter int WIDTH = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            left_q  <= '0;
            pulse_o <= 1'b0;
        end else if (trig_i) begin
            left_q  <= CW'(WIDTH - 1);
            pulse_o <= 1'b1;
        end else if (left_q != '0) begin
            left_q  <= left_q - 1'b1;
        end else begin
            pulse_o <= 1'b0;
        end
    end

    AST_STRETCH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_i |=> pulse_o); // R8
    AST_STRETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pulse_o && left_q != '0) |=> pulse_o); // R10
endmodule

// File: rtl/decade_pps_divider.sv
module decade_pps_divider #(
    parameter int NSTAGES = 7,
    parameter int RADIX   = 10,
    parameter int PULSE_W = 100,
    parameter int SYNC_FF = 2,
    parameter int SEL_W   = $clog2(NSTAGES + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               ref_pps_i,
    input  logic               arm_i,
    input  logic [SEL_W-1:0]   rate_sel_i,
    output logic [NSTAGES-1:0] tick_o,
    output logic               pps_o,
    output logic               rate_o,
    output logic               armed_o
);
    localparam int LAST = NSTAGES - 1;

    logic               rise;
    logic               load;
    logic [NSTAGES-1:0] en;
    logic [NSTAGES-1:0] wrap;
    logic [NSTAGES-1:0] tick_q;
    logic [SEL_W-1:0]   sel_idx;
    logic               wrap_sel;

    ppsdiv_ref_sync #(.SYNC_FF(SYNC_FF)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ref_i  (ref_pps_i),
        .rise_o (rise)
    );

    ppsdiv_sync_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .arm_i   (arm_i),
        .rise_i  (rise),
        .load_o  (load),
        .armed_o (armed_o)
    );

    generate
        for (genvar i = 0; i < NSTAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign en[i] = 1'b1;
            end else begin : g_next
                assign en[i] = wrap[i-1];
            end
            ppsdiv_decade_stage #(.RADIX(RADIX)) u_dig (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .load_i (load),
                .en_i   (en[i]),
                .wrap_o (wrap[i])
            );
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tick_q <= '0;
        end else begin
            tick_q <= wrap & {NSTAGES{~load}};
        end
    end

    assign tick_o = tick_q;

    always_comb begin
        sel_idx  = (rate_sel_i >= SEL_W'(NSTAGES)) ? SEL_W'(LAST) : rate_sel_i;
        wrap_sel = 1'b0;
        for (int i = 0; i < NSTAGES; i++) begin
            if (int'(sel_idx) == i) wrap_sel = wrap[i];
        end
    end

    ppsdiv_stretch #(.WIDTH(PULSE_W)) u_pps_str (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trig_i  (wrap[LAST] & ~load),
        .pulse_o (pps_o)
    );

    ppsdiv_stretch #(.WIDTH(PULSE_W)) u_rate_str (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trig_i  (wrap_sel & ~load),
        .pulse_o (rate_o)
    );

    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_q[LAST] |=> !tick_q[LAST]); // R2
    AST_PPS_WITH_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_q[LAST] |-> pps_o); // R8

    generate
        for (genvar i = 1; i < NSTAGES; i++) begin : g_nest
            AST_TICK_NESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_q[i] |-> tick_q[i-1]); // R3
        end
    endgenerate
endmodule

// File: tb/sim_decade_pps_divider.sv
module sim_decade_pps_divider;
    localparam int NS = 3;
    localparam int RX = 10;
    localparam int PW = 20;
    localparam int SW = 2;
    localparam int NTOT = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_p = 1'b0;
    logic          arm = 1'b0;
    logic [SW-1:0] sel = '0;
    logic [NS-1:0] tick;
    logic          pps, rate, armed;

    int k, base, sel_stage, nvec, nfail;
    bit done;

    always #10 clk = ~clk;

    decade_pps_divider #(.NSTAGES(NS), .RADIX(RX), .PULSE_W(PW), .SYNC_FF(2), .SEL_W(SW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .ref_pps_i(ref_p), .arm_i(arm),
        .rate_sel_i(sel), .tick_o(tick), .pps_o(pps), .rate_o(rate), .armed_o(armed)
    );

    function automatic int pw10(input int e);
        int r = 1;
        for (int i = 0; i < e; i++) r = r * RX;
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, k);
        end
    endtask

    task automatic sample_all();
        int m = k - base;
        int ps = pw10(sel_stage + 1);
        for (int i = 0; i < NS; i++) begin
            int p = pw10(i + 1);
            chk("R2 tick", int'(tick[i]), int'(m > 0 && m % p == 0));
        end
        if (tick[NS-1]) chk("R3 nesting", int'(&tick), 1);
        chk("R8 pps width", int'(pps), int'(m >= NTOT && m % NTOT < PW));
        chk("R9/R10 rate", int'(rate), int'(m >= ps && m % ps < PW));
    endtask

    task automatic step_to(input int upto);
        while (k < upto) begin
            @(negedge clk);
            k++;
            sample_all();
        end
    endtask

    task automatic do_reset(input logic [SW-1:0] s, input int stage);
        @(negedge clk);
        rst_n = 1'b0; arm = 1'b0; ref_p = 1'b0; sel = s;
        repeat (3) @(negedge clk);
        chk("R1 tick reset", int'(tick), 0);
        chk("R1 pps reset", int'(pps), 0);
        chk("R1 rate reset", int'(rate), 0);
        chk("R1 armed reset", int'(armed), 0);
        rst_n = 1'b1;
        k = 0; base = 0; sel_stage = stage;
    endtask

    // R2 R3 R8 and out-of-range select R9
    task automatic t_free_run();
        do_reset(2'd3, 2);
        step_to(2100);
        chk("R6 armed idle", int'(armed), 0);
    endtask

    // R10: selected period 10 below pulse width 20
    task automatic t_fast_rate();
        do_reset(2'd0, 0);
        step_to(300);
    endtask

    // R6: edges while disarmed, rate stage 1
    task automatic t_ignore_ref();
        do_reset(2'd1, 1);
        step_to(50);  ref_p = 1'b1;
        step_to(60);  ref_p = 1'b0;
        step_to(500); ref_p = 1'b1;
        step_to(520); ref_p = 1'b0;
        step_to(1300); ref_p = 1'b1;
        step_to(1310); ref_p = 1'b0;
        step_to(2100);
        chk("R6 never armed", int'(armed), 0);
    endtask

    // R4 R5 R11
    task automatic t_align();
        do_reset(2'd2, 2);
        step_to(350); arm = 1'b1;
        step_to(351); arm = 1'b0;
        chk("R4 armed", int'(armed), 1);
        step_to(360); ref_p = 1'b1;
        step_to(363);
        chk("R5 still armed", int'(armed), 1);
        base = 364;
        step_to(364);
        chk("R5 disarm at load", int'(armed), 0);
        step_to(400); ref_p = 1'b0;
        step_to(700); ref_p = 1'b1;
        step_to(800); ref_p = 1'b0;
        step_to(364 + 2100);
        chk("R11 stays disarmed", int'(armed), 0);
    endtask

    // R7: level already high when armed
    task automatic t_level_ref();
        do_reset(2'd2, 2);
        step_to(100); ref_p = 1'b1;
        step_to(300); arm = 1'b1;
        step_to(301); arm = 1'b0;
        step_to(400);
        chk("R7 no align on level", int'(armed), 1);
        ref_p = 1'b0;
        step_to(600); ref_p = 1'b1;
        step_to(603);
        base = 604;
        step_to(604);
        chk("R7 align on rise", int'(armed), 0);
        step_to(604 + 1100);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        nvec = 0; nfail = 0; done = 1'b0; k = 0; base = 0; sel_stage = 2;
        t_free_run();
        t_fast_rate();
        t_ignore_ref();
        t_align();
        t_level_ref();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule